// File: doc/BRIEF.md
# Edge Inference Power-Mode Sequencer

This block decides which power domains of an always-on inference device are switched on. It has three resting modes. In deep sleep only this management logic runs. In monitoring the signal front end and the neural engine stream continuously. In host alert the serial links to the host are also powered. A wake request leaves deep sleep. A detection during monitoring raises an alert. The host ends the alert, or a programmable cycle limit ends it when the host does not respond. A sleep command returns the device to deep sleep from monitoring.

The domains come up in order over two clock cycles: the front end first, then the neural engine. They go down in the reverse order. While the device is monitoring, the block watches a stream of ambient noise estimates. After a long run of quiet samples it asks the clock generator to divide the processing clock by four. It asks for full speed again as soon as a loud sample arrives, or as soon as the device leaves monitoring.

Top module: `edge_power_sequencer`

## Requirements
- R1: After reset `mode` is 0 (deep sleep), all four enables are low and `div_code` is 0 (divide by 1). The `mode` encoding is 0 sleep, 1 monitoring, 2 alert, 3 transition between domains.
- R2: `wake_req` in deep sleep gives `mode`=3 with `dsp_en`=1 and `nn_en`=0 after the next edge, then `mode`=1 with both enables high after the edge after that. `wake_req` has no effect in any other state.
- R3: `detect` in monitoring gives `mode`=2 after the next edge, and `bulk_link_en` and `cmd_link_en` are high only in that state. `detect` in deep sleep has no effect.
- R4: `host_done` in alert returns the block to `mode`=1 at the next edge, with the link enables low.
- R5: Alert lasts at most `alert_limit` cycles before the block returns to monitoring on its own. An `alert_limit` of 0 acts as 1.
- R6: `sleep_cmd` in monitoring gives `mode`=3 with `nn_en`=0 and `dsp_en`=1 after the next edge, then deep sleep with all enables low. It is ignored in alert. When `detect` and `sleep_cmd` arrive together in monitoring, `detect` wins.
- R7: In monitoring, once `QUIET_RUN` consecutive valid samples (`noise_vld`=1) have `noise_lvl` < `quiet_thr`, `div_code` becomes 2 (divide by 4). Cycles with `noise_vld`=0 neither count toward the run nor break it.
- R8: A valid sample with `noise_lvl` >= `quiet_thr` sets `div_code` back to 0 at the next edge and restarts the quiet run from zero.
- R9: `div_code` is 0 whenever `mode` is not 1. Leaving monitoring discards the quiet run, so a new full run is needed after returning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| wake_req | input | 1 | Leave deep sleep |
| detect | input | 1 | Pattern detection event |
| host_done | input | 1 | Host has finished the alert exchange |
| sleep_cmd | input | 1 | Return to deep sleep |
| alert_limit | input | TIMEOUT_W | Maximum alert length in cycles |
| noise_vld | input | 1 | Noise estimate strobe |
| noise_lvl | input | NOISE_W | Ambient noise estimate |
| quiet_thr | input | NOISE_W | Level below which a sample counts as quiet |
| dsp_en | output | 1 | Signal front-end domain enable |
| nn_en | output | 1 | Neural engine domain enable |
| bulk_link_en | output | 1 | High-speed serial host link enable |
| cmd_link_en | output | 1 | Low-speed command link enable |
| div_code | output | 2 | Log2 of processing clock divide ratio (0 or 2) |
| mode | output | 2 | Current mode, encoded as in R1 |

## Verification
The bench builds the block with `QUIET_RUN`=8 and `TIMEOUT_W`=8 in place of the defaults of 256 and 16. With these values it can reach the exact sample on which the quiet run completes and divide-by-4 starts, and show that a single loud sample restarts the run. The alert limits it uses are small, 3 and 0, so it can count the last alert cycle before the block returns to monitoring on its own.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP   = 3'd0,
    ST_RAMP_UP = 3'd1,
    ST_MONITOR = 3'd2,
    ST_ALERT   = 3'd3,
    ST_RAMP_DN = 3'd4
  } pwr_state_t;

  localparam logic [1:0] MODE_SLEEP   = 2'd0;
  localparam logic [1:0] MODE_MONITOR = 2'd1;
  localparam logic [1:0] MODE_ALERT   = 2'd2;
  localparam logic [1:0] MODE_TRANS   = 2'd3;

  typedef struct packed {
    logic dsp;
    logic nn;
    logic bulk;
    logic cmd;
  } dom_en_t;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_seq_pkg::*;
#(
  parameter int TIMEOUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_req,
  input  logic                 detect,
  input  logic                 host_done,
  input  logic                 sleep_cmd,
  input  logic [TIMEOUT_W-1:0] alert_limit,
  output pwr_state_t           state_o
);
  localparam int CW = TIMEOUT_W + 1;

  pwr_state_t           state_q, state_d;
  logic [TIMEOUT_W-1:0] tmr_q, tmr_d;
  logic                 tmr_en;
  logic                 expired;

  assign expired = ({1'b0, tmr_q} + CW'(1)) >= {1'b0, alert_limit};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP:   if (wake_req) state_d = ST_RAMP_UP;
      ST_RAMP_UP: state_d = ST_MONITOR;
      ST_MONITOR: begin
        if (detect)         state_d = ST_ALERT;
        else if (sleep_cmd) state_d = ST_RAMP_DN;
      end
      ST_ALERT:   if (host_done || expired) state_d = ST_MONITOR;
      ST_RAMP_DN: state_d = ST_SLEEP;
      default:    state_d = ST_SLEEP;
    endcase
  end

  always_comb begin
    tmr_en = 1'b0;
    tmr_d  = tmr_q;
    if (state_q != ST_ALERT) begin
      tmr_en = (tmr_q != '0);
      tmr_d  = '0;
    end else if (!expired) begin
      tmr_en = 1'b1;
      tmr_d  = tmr_q + TIMEOUT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SLEEP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_quiet_track.sv
module pwr_quiet_track #(
  parameter int NOISE_W   = 8,
  parameter int QUIET_RUN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               track_en,
  input  logic               noise_vld,
  input  logic [NOISE_W-1:0] noise_lvl,
  input  logic [NOISE_W-1:0] quiet_thr,
  output logic               slow_o
);
  localparam int QW = (QUIET_RUN > 2) ? $clog2(QUIET_RUN) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUIET_RUN - 1);

  logic [QW-1:0] run_q, run_d;
  logic          slow_q, slow_d;
  logic          upd_en;
  logic          is_quiet;

  assign is_quiet = noise_lvl < quiet_thr;

  always_comb begin
    upd_en = 1'b0;
    run_d  = run_q;
    slow_d = slow_q;
    if (!track_en) begin
      upd_en = 1'b1;
      run_d  = '0;
      slow_d = 1'b0;
    end else if (noise_vld) begin
      upd_en = 1'b1;
      if (!is_quiet) begin
        run_d  = '0;
        slow_d = 1'b0;
      end else if (run_q == LAST) begin
        slow_d = 1'b1;
      end else begin
        run_d = run_q + QW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      slow_q <= 1'b0;
    end else if (upd_en) begin
      run_q  <= run_d;
      slow_q <= slow_d;
    end
  end

  assign slow_o = slow_q;
endmodule

// File: rtl/pwr_domain_decode.sv
module pwr_domain_decode
  import pwr_seq_pkg::*;
#(
  parameter int SLOW_DIV_LOG2 = 2
) (
  input  pwr_state_t state,
  input  logic       slow,
  output dom_en_t    en,
  output logic [1:0] div_code,
  output logic [1:0] mode
);
  always_comb begin
    en   = '0;
    mode = MODE_SLEEP;
    unique case (state)
      ST_SLEEP:   mode = MODE_SLEEP;
      ST_RAMP_UP: begin en.dsp = 1'b1; mode = MODE_TRANS; end
      ST_MONITOR: begin en.dsp = 1'b1; en.nn = 1'b1; mode = MODE_MONITOR; end
      ST_ALERT: begin
        en   = '1;
        mode = MODE_ALERT;
      end
      ST_RAMP_DN: begin en.dsp = 1'b1; mode = MODE_TRANS; end
      default:    mode = MODE_SLEEP;
    endcase
  end

  assign div_code = (state == ST_MONITOR && slow) ? 2'(SLOW_DIV_LOG2) : 2'd0;
endmodule

// File: rtl/edge_power_sequencer.sv
module edge_power_sequencer
  import pwr_seq_pkg::*;
#(
  parameter int TIMEOUT_W     = 16,
  parameter int NOISE_W       = 8,
  parameter int QUIET_RUN     = 256,
  parameter int SLOW_DIV_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_req,
  input  logic                 detect,
  input  logic                 host_done,
  input  logic                 sleep_cmd,
  input  logic [TIMEOUT_W-1:0] alert_limit,
  input  logic                 noise_vld,
  input  logic [NOISE_W-1:0]   noise_lvl,
  input  logic [NOISE_W-1:0]   quiet_thr,
  output logic                 dsp_en,
  output logic                 nn_en,
  output logic                 bulk_link_en,
  output logic                 cmd_link_en,
  output logic [1:0]           div_code,
  output logic [1:0]           mode
);
  logic       rst_n_s;
  pwr_state_t state;
  logic       slow;
  dom_en_t    en;

  pwr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  pwr_mode_fsm #(.TIMEOUT_W(TIMEOUT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .wake_req(wake_req), .detect(detect),
    .host_done(host_done), .sleep_cmd(sleep_cmd), .alert_limit(alert_limit),
    .state_o(state)
  );

  pwr_quiet_track #(.NOISE_W(NOISE_W), .QUIET_RUN(QUIET_RUN)) u_quiet (
    .clk(clk), .rst_n(rst_n_s), .track_en(state == ST_MONITOR),
    .noise_vld(noise_vld), .noise_lvl(noise_lvl), .quiet_thr(quiet_thr),
    .slow_o(slow)
  );

  pwr_domain_decode #(.SLOW_DIV_LOG2(SLOW_DIV_LOG2)) u_dec (
    .state(state), .slow(slow), .en(en), .div_code(div_code), .mode(mode)
  );

  assign dsp_en       = en.dsp;
  assign nn_en        = en.nn;
  assign bulk_link_en = en.bulk;
  assign cmd_link_en  = en.cmd;
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker #(
  parameter int TIMEOUT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [TIMEOUT_W-1:0] alert_limit,
  input logic                 dsp_en,
  input logic                 nn_en,
  input logic                 bulk_link_en,
  input logic                 cmd_link_en,
  input logic [1:0]           div_code,
  input logic [1:0]           mode
);
  logic [TIMEOUT_W:0] alert_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             alert_run_q <= '0;
    else if (mode == 2'd2)  alert_run_q <= alert_run_q + 1'b1;
    else                    alert_run_q <= '0;
  end

  AST_NN_NEEDS_DSP: assert property (@(posedge clk) disable iff (!rst_n)
    nn_en |-> dsp_en); // R2

  AST_WAKE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nn_en) |-> $past(dsp_en)); // R2

  AST_SLEEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsp_en) |-> !$past(nn_en)); // R6

  AST_LINKS_ONLY_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_link_en || cmd_link_en) |-> (mode == 2'd2)); // R3

  AST_ALERT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (alert_run_q == '0 || alert_run_q < {1'b0, alert_limit})); // R5

  AST_DIV_ONLY_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code != 2'd0) |-> (mode == 2'd1)); // R9

  AST_SLEEP_VIA_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(mode) != 2'd0) |-> ($past(mode) == 2'd3)); // R6
endmodule

bind edge_power_sequencer pwr_seq_checker #(.TIMEOUT_W(TIMEOUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alert_limit(alert_limit), .dsp_en(dsp_en),
  .nn_en(nn_en), .bulk_link_en(bulk_link_en), .cmd_link_en(cmd_link_en),
  .div_code(div_code), .mode(mode)
);

// File: tb/edge_power_sequencer_test.sv
module edge_power_sequencer_test;
  localparam int TW = 8;
  localparam int NW = 8;
  localparam int QR = 8;

  logic clk, rst_n, wake_req, detect, host_done, sleep_cmd, noise_vld;
  logic [TW-1:0] alert_limit;
  logic [NW-1:0] noise_lvl, quiet_thr;
  logic dsp_en, nn_en, bulk_link_en, cmd_link_en;
  logic [1:0] div_code, mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  edge_power_sequencer #(.TIMEOUT_W(TW), .NOISE_W(NW), .QUIET_RUN(QR)) uut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .detect(detect),
    .host_done(host_done), .sleep_cmd(sleep_cmd), .alert_limit(alert_limit),
    .noise_vld(noise_vld), .noise_lvl(noise_lvl), .quiet_thr(quiet_thr),
    .dsp_en(dsp_en), .nn_en(nn_en), .bulk_link_en(bulk_link_en),
    .cmd_link_en(cmd_link_en), .div_code(div_code), .mode(mode)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // Row: wake det done sleep | mode[1:0] | dsp nn bulk cmd ; alert_limit = 3
  localparam logic [9:0] VEC [17] = '{
    10'b0000_00_0000, // idle in sleep, R1
    10'b0100_00_0000, // detect ignored in sleep, R3
    10'b0001_00_0000, // sleep command in sleep: no effect
    10'b1000_11_1000, // wake: front end first, R2
    10'b1000_01_1100, // then neural engine; extra wake ignored, R2
    10'b0000_01_1100, // monitoring holds
    10'b0100_10_1111, // detect -> alert, links on, R3
    10'b0001_10_1111, // sleep ignored in alert, R6
    10'b0000_10_1111, // third alert cycle
    10'b0000_01_1100, // timeout after 3 cycles, R5
    10'b0100_10_1111, // detect again
    10'b0010_01_1100, // host done exits, R4
    10'b0101_10_1111, // detect wins over sleep, R6
    10'b0010_01_1100, // host done
    10'b0001_11_1000, // sleep: neural engine off first, R6
    10'b1000_00_0000, // then all off; wake ignored in ramp down
    10'b0000_00_0000
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic clr_inputs();
    wake_req = 0; detect = 0; host_done = 0; sleep_cmd = 0; noise_vld = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    clr_inputs();
    repeat (2) tick();
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic pulse(input bit w, input bit d, input bit h, input bit s);
    wake_req = w; detect = d; host_done = h; sleep_cmd = s;
    tick();
    clr_inputs();
  endtask

  task automatic sample(input logic [NW-1:0] lvl);
    noise_vld = 1; noise_lvl = lvl;
    tick();
    noise_vld = 0; noise_lvl = 8'hEE;
    tick();
  endtask

  initial begin
    rst_n = 0;
    clr_inputs();
    alert_limit = 8'd3;
    noise_lvl = 8'd50;
    quiet_thr = 8'd10;
    do_reset();
    check("R1 reset mode", 32'(mode), 32'd0);
    check("R1 reset enables", {28'd0, dsp_en, nn_en, bulk_link_en, cmd_link_en}, 32'd0);
    check("R1 reset div", 32'(div_code), 32'd0);

    for (int i = 0; i < 17; i++) begin
      {wake_req, detect, host_done, sleep_cmd} = VEC[i][9:6];
      tick();
      clr_inputs();
      checks++;
      if ({mode, dsp_en, nn_en, bulk_link_en, cmd_link_en} !== VEC[i][5:0]) begin
        failures++;
        $display("FAIL R2/R3/R4/R5/R6 row %0d actual=%b expected=%b", i,
                 {mode, dsp_en, nn_en, bulk_link_en, cmd_link_en}, VEC[i][5:0]);
      end
    end

    // R5: limit 0 acts as one cycle
    alert_limit = 8'd0;
    pulse(1, 0, 0, 0); tick();
    pulse(0, 1, 0, 0);
    check("R5 limit0 first alert cycle", 32'(mode), 32'd2);
    tick();
    check("R5 limit0 exit", 32'(mode), 32'd1);
    alert_limit = 8'd3;

    // R7: quiet run completes on the QR-th valid quiet sample
    for (int k = 0; k < QR - 1; k++) sample(8'd3);
    check("R7 div before run complete", 32'(div_code), 32'd0);
    sample(8'd9);
    check("R7 div after quiet run", 32'(div_code), 32'd2);
    // R8: sample equal to threshold is loud
    sample(8'd10);
    check("R8 loud restores div", 32'(div_code), 32'd0);
    for (int k = 0; k < QR - 1; k++) sample(8'd2);
    sample(8'd40);
    for (int k = 0; k < QR - 1; k++) sample(8'd2);
    check("R8 run restarted by loud", 32'(div_code), 32'd0);
    sample(8'd2);
    check("R7 div after fresh run", 32'(div_code), 32'd2);

    // R9: alert forces divide by 1 and discards the run
    pulse(0, 1, 0, 0);
    check("R9 div in alert", 32'(div_code), 32'd0);
    pulse(0, 0, 1, 0);
    check("R9 back in monitor", 32'(mode), 32'd1);
    sample(8'd2);
    check("R9 run discarded", 32'(div_code), 32'd0);

    // R1: reset during alert
    pulse(0, 1, 0, 0);
    check("R3 alert before reset", 32'(mode), 32'd2);
    do_reset();
    check("R1 reset from alert", {26'd0, mode, dsp_en, nn_en, bulk_link_en, cmd_link_en}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule